// File: doc/BRIEF.md
# Clock Leaf Sleep Handshake Controller

This block decides, leaf by leaf, when a clock leaf may be stopped and when it must run again. Every leaf carries a two-bit setting: a run-enable bit and an enrol bit. A leaf that is not enrolled sleeps when its run-enable bit is cleared. An enrolled leaf ignores its own run-enable bit and follows one shared power-down bit, so a single write sleeps or wakes every enrolled leaf at once. A leaf never stops its clock on its own. It first raises a disable request toward the bus side and holds its clock until that request is granted. Only then is the clock stopped, and the request is withdrawn one cycle later.

Software sees the configured setting and the live state in separate registers, because a sleep takes several cycles to complete. Leaves are grouped into branches. A per-branch summary bit drops to 0 only once every leaf of that branch has fully finished the sleep sequence, which tells software the branch clock itself can be shut off. The actual gating cells, clock sources and dividers are outside the block: it drives one clock-enable and one request per leaf and takes one grant per leaf. The register port is a plain single-cycle port: a write takes effect at the clock edge where `reg_wen` is high, and a read is combinational on `reg_addr`. It has no back-pressure.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset the power-down register reads 0, every leaf configuration reads 1 (run enabled, not enrolled), the branch summary reads all ones (0x1FFF for 13 branches), every `leaf_clk_en` is 1 and every `bus_req` is 0.
- R2: The register map is word aligned. 0x000 is power-down (bit 0), 0x004 is branch summary (bit b for branch b), leaf i configuration is at 0x100 + 8*i (bit 0 run-enable, bit 1 enrol), and leaf i status is at 0x104 + 8*i. The status register holds the configuration in bits [1:0] and the live state in bits [3:2], encoded run=00, wait=01, sleep0=10, sleep1=11. Unmapped addresses read 0.
- R3: A leaf whose sleep condition becomes true enters wait one cycle after the register update. In wait it asserts `bus_req` and keeps `leaf_clk_en` at 1 for as long as no grant arrives.
- R4: A grant sampled in wait moves the leaf to sleep0 at that edge. In sleep0 `leaf_clk_en` is 0 and `bus_req` is still 1.
- R5: From sleep0 the leaf moves to sleep1 on the next edge. In sleep1 `bus_req` is 0 and `leaf_clk_en` stays 0.
- R6: Removing the sleep condition in sleep0 or sleep1 returns the leaf to run on the next edge with `leaf_clk_en` at 1.
- R7: Removing the sleep condition in wait returns the leaf to run and drops `bus_req` without `leaf_clk_en` ever going to 0.
- R8: An enrolled leaf sleeps exactly when power-down is 1, whatever its run-enable bit. A leaf that is not enrolled ignores power-down.
- R9: Branch bit b is 0 only while every leaf of branch b (leaves 2b and 2b+1) is in sleep1. Otherwise it is 1.
- R10: Writes to the status addresses and to the branch summary address change no register and no output.
- R11: A grant that arrives while a leaf is not in wait has no effect on that leaf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register byte address |
| reg_wen | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| bus_gnt | input | 26 | Per-leaf grant of the disable request |
| bus_req | output | 26 | Per-leaf disable request |
| leaf_clk_en | output | 26 | Per-leaf clock enable for the external gating cell |
| branch_active | output | 13 | Per-branch summary, 0 when all leaves are in sleep1 |

## Verification
A register write lands at the edge where `reg_wen` is sampled, and every leaf reacts at the edge after that one. So wait, or the return to run, is due one edge after the write, sleep0 at the first edge with a grant, and sleep1 one edge later. The branch bit and the status readback are combinational on the leaf state, so they change in the same cycle as the state. The bench drives all inputs at the falling edge, steps whole cycles from falling edge to falling edge, and checks each result at the exact step where it is due. Holding and abort cases are checked at every intermediate step, not only at the end.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef enum logic [1:0] {
    LS_RUN    = 2'b00,
    LS_WAIT   = 2'b01,
    LS_SLEEP0 = 2'b10,
    LS_SLEEP1 = 2'b11
  } leaf_state_e;

  typedef struct packed {
    logic enrolled;
    logic run_en;
  } leaf_cfg_t;

  localparam int unsigned PD_ADDR     = 32'h000;
  localparam int unsigned BRANCH_ADDR = 32'h004;
  localparam int unsigned LEAF_BASE   = 32'h100;
  localparam int unsigned LEAF_STRIDE = 8;

endpackage

// File: rtl/clkgate_leaf_fsm.sv
module clkgate_leaf_fsm
  import clkgate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_req,
  input  logic        gnt,
  output logic        clk_en,
  output logic        req,
  output leaf_state_e state
);

  leaf_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      LS_RUN:    if (sleep_req) nxt = LS_WAIT;
      LS_WAIT:   if (!sleep_req) nxt = LS_RUN;
                 else if (gnt)   nxt = LS_SLEEP0;
      LS_SLEEP0: nxt = sleep_req ? LS_SLEEP1 : LS_RUN;
      LS_SLEEP1: if (!sleep_req) nxt = LS_RUN;
      default:   nxt = LS_RUN;
    endcase
  end

  // Outputs come straight from flops so the gating cell sees clean levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LS_RUN;
      clk_en <= 1'b1;
      req    <= 1'b0;
    end else begin
      state  <= nxt;
      clk_en <= !(nxt == LS_SLEEP0 || nxt == LS_SLEEP1);
      req    <= (nxt == LS_WAIT || nxt == LS_SLEEP0);
    end
  end

  a_r3_request_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_RUN && sleep_req) |=> (state == LS_WAIT && req && clk_en));

  a_r4_grant_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_WAIT && sleep_req && gnt) |=> (state == LS_SLEEP0 && !clk_en && req));

  a_r5_release_request: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_SLEEP0 && sleep_req) |=> (state == LS_SLEEP1 && !req && !clk_en));

  a_r6_fast_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == LS_SLEEP0 || state == LS_SLEEP1) && !sleep_req) |=> (clk_en && state == LS_RUN));

  a_r7_gate_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> ($past(gnt) && $past(state == LS_WAIT)));

endmodule

// File: rtl/clkgate_branch_sum.sv
module clkgate_branch_sum
  import clkgate_pkg::*;
#(
  parameter int N_BRANCH    = 13,
  parameter int LEAF_PER_BR = 2,
  localparam int NUM_LEAF   = N_BRANCH * LEAF_PER_BR
) (
  input  logic [NUM_LEAF-1:0][1:0] state_vec,
  output logic [N_BRANCH-1:0]      active
);

  for (genvar b = 0; b < N_BRANCH; b++) begin : g_br
    always_comb begin
      active[b] = 1'b0;
      for (int j = 0; j < LEAF_PER_BR; j++) begin
        if (state_vec[b*LEAF_PER_BR + j] != LS_SLEEP1) active[b] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/clkgate_regfile.sv
module clkgate_regfile
  import clkgate_pkg::*;
#(
  parameter int N_BRANCH    = 13,
  parameter int LEAF_PER_BR = 2,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  localparam int NUM_LEAF   = N_BRANCH * LEAF_PER_BR,
  localparam int IDX_W      = (NUM_LEAF > 1) ? $clog2(NUM_LEAF) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_wen,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [NUM_LEAF-1:0][1:0] state_vec,
  input  logic [N_BRANCH-1:0]      branch_active,
  output logic                     pd,
  output leaf_cfg_t [NUM_LEAF-1:0] cfg
);

  localparam int unsigned LEAF_END = LEAF_BASE + LEAF_STRIDE * NUM_LEAF;

  int unsigned a_int;
  logic        aligned;
  logic        hit_pd;
  logic        hit_br;
  logic        hit_leaf;
  logic        sel_stat;
  logic [IDX_W-1:0] idx;
  logic        unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:2];

  always_comb begin
    a_int    = 32'(reg_addr);
    aligned  = (reg_addr[1:0] == 2'b00);
    hit_pd   = aligned && (a_int == PD_ADDR);
    hit_br   = aligned && (a_int == BRANCH_ADDR);
    hit_leaf = aligned && (a_int >= LEAF_BASE) && (a_int < LEAF_END);
    sel_stat = reg_addr[2];
    idx      = IDX_W'((a_int - LEAF_BASE) / LEAF_STRIDE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd <= 1'b0;
      for (int i = 0; i < NUM_LEAF; i++) cfg[i] <= '{enrolled: 1'b0, run_en: 1'b1};
    end else if (reg_wen) begin
      if (hit_pd) pd <= reg_wdata[0];
      if (hit_leaf && !sel_stat) cfg[idx] <= leaf_cfg_t'(reg_wdata[1:0]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_pd)                    reg_rdata = DATA_W'(pd);
    else if (hit_br)               reg_rdata = DATA_W'(branch_active);
    else if (hit_leaf && sel_stat) reg_rdata = DATA_W'({state_vec[idx], cfg[idx]});
    else if (hit_leaf)             reg_rdata = DATA_W'(cfg[idx]);
  end

  a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && hit_leaf && sel_stat) |=> ($stable(cfg) && $stable(pd)));

  a_r10_branch_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && hit_br) |=> ($stable(cfg) && $stable(pd)));

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int N_BRANCH    = 13,
  parameter int LEAF_PER_BR = 2,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  localparam int NUM_LEAF   = N_BRANCH * LEAF_PER_BR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wen,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_LEAF-1:0] bus_gnt,
  output logic [NUM_LEAF-1:0] bus_req,
  output logic [NUM_LEAF-1:0] leaf_clk_en,
  output logic [N_BRANCH-1:0] branch_active
);

  logic                     pd;
  leaf_cfg_t [NUM_LEAF-1:0] cfg;
  logic [NUM_LEAF-1:0][1:0] state_vec;
  logic [NUM_LEAF-1:0]      sleep_req;

  clkgate_regfile #(
    .N_BRANCH(N_BRANCH), .LEAF_PER_BR(LEAF_PER_BR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .state_vec(state_vec), .branch_active(branch_active),
    .pd(pd), .cfg(cfg)
  );

  for (genvar i = 0; i < NUM_LEAF; i++) begin : g_leaf
    leaf_state_e st;

    // Enrolled leaves track the shared power-down bit; others their own enable.
    assign sleep_req[i] = cfg[i].enrolled ? pd : !cfg[i].run_en;
    assign state_vec[i] = st;

    clkgate_leaf_fsm i_fsm (
      .clk(clk), .rst_n(rst_n),
      .sleep_req(sleep_req[i]), .gnt(bus_gnt[i]),
      .clk_en(leaf_clk_en[i]), .req(bus_req[i]), .state(st)
    );
  end

  clkgate_branch_sum #(.N_BRANCH(N_BRANCH), .LEAF_PER_BR(LEAF_PER_BR)) i_sum (
    .state_vec(state_vec), .active(branch_active)
  );

  for (genvar b = 0; b < N_BRANCH; b++) begin : g_chk
    a_r9_branch_low_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !branch_active[b] |->
        (leaf_clk_en[b*LEAF_PER_BR +: LEAF_PER_BR] == '0) &&
        (bus_req[b*LEAF_PER_BR +: LEAF_PER_BR] == '0));
  end

  a_r8_pd_write_reaches_enrolled: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(PD_ADDR) && reg_wdata[0]) |=> pd);

endmodule

// File: tb/test_clkgate_ctrl.sv
`timescale 1ns/1ps
module test_clkgate_ctrl;

  localparam int NB = 13;
  localparam int NL = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic          reg_wen = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] bus_gnt = '0;
  logic [NL-1:0] bus_req;
  logic [NL-1:0] leaf_clk_en;
  logic [NB-1:0] branch_active;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkgate_ctrl i_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .leaf_clk_en(leaf_clk_en),
    .branch_active(branch_active)
  );

  function automatic logic [11:0] cfg_a(int i);  return 12'(32'h100 + 8*i); endfunction
  function automatic logic [11:0] stat_a(int i); return 12'(32'h104 + 8*i); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h000, d);    chk("R1 pd reset", d, 32'h0);
    rd(12'h004, d);    chk("R1 branch reset", d, 32'h1FFF);
    rd(cfg_a(0), d);   chk("R1 cfg reset", d, 32'h1);
    rd(cfg_a(25), d);  chk("R1 last cfg reset", d, 32'h1);
    rd(stat_a(0), d);  chk("R2 status reset run", d, 32'h1);
    chk("R1 clk_en reset", 32'(leaf_clk_en), 32'h3FF_FFFF);
    chk("R1 req reset", 32'(bus_req), 32'h0);
  endtask

  task automatic t_handshake();
    logic [31:0] d;
    wr(cfg_a(0), 32'h0);
    step(1);
    rd(stat_a(0), d);  chk("R2 R3 status wait", d, 32'h4);
    chk("R3 req in wait", 32'(bus_req[0]), 32'h1);
    chk("R3 clk held in wait", 32'(leaf_clk_en[0]), 32'h1);
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk("R3 waits for grant", 32'(leaf_clk_en[0]), 32'h1);
    end
    bus_gnt[0] = 1'b1;
    step(1);
    bus_gnt[0] = 1'b0;
    rd(stat_a(0), d);  chk("R4 status sleep0", d, 32'h8);
    chk("R4 clk off", 32'(leaf_clk_en[0]), 32'h0);
    chk("R4 req held", 32'(bus_req[0]), 32'h1);
    step(1);
    rd(stat_a(0), d);  chk("R5 status sleep1", d, 32'hC);
    chk("R5 req dropped", 32'(bus_req[0]), 32'h0);
    chk("R5 clk off", 32'(leaf_clk_en[0]), 32'h0);
    rd(12'h004, d);    chk("R9 branch 0 partly awake", d, 32'h1FFF);
    wr(cfg_a(0), 32'h1);
    step(1);
    chk("R6 clk back", 32'(leaf_clk_en[0]), 32'h1);
    rd(stat_a(0), d);  chk("R6 status run", d, 32'h1);
  endtask

  task automatic t_branch();
    logic [31:0] d;
    bus_gnt[3:2] = 2'b11;
    wr(cfg_a(2), 32'h0);
    wr(cfg_a(3), 32'h0);
    step(4);
    rd(12'h004, d);    chk("R9 branch 1 asleep", d, 32'h1FFD);
    chk("R9 clk_en branch 1", 32'(leaf_clk_en[3:2]), 32'h0);
    wr(cfg_a(3), 32'h1);
    step(1);
    rd(12'h004, d);    chk("R9 branch 1 wakes", d, 32'h1FFF);
    chk("R6 leaf 3 clk back", 32'(leaf_clk_en[3]), 32'h1);
    wr(cfg_a(2), 32'h1);
    step(1);
    bus_gnt[3:2] = 2'b00;
  endtask

  task automatic t_abort();
    logic [31:0] d;
    wr(cfg_a(4), 32'h0);
    step(1);
    chk("R7 req raised", 32'(bus_req[4]), 32'h1);
    for (int k = 0; k < 2; k++) begin
      step(1);
      chk("R7 clk never drops", 32'(leaf_clk_en[4]), 32'h1);
    end
    wr(cfg_a(4), 32'h1);
    chk("R7 clk never drops", 32'(leaf_clk_en[4]), 32'h1);
    step(1);
    chk("R7 req withdrawn", 32'(bus_req[4]), 32'h0);
    chk("R7 clk on", 32'(leaf_clk_en[4]), 32'h1);
    rd(stat_a(4), d);  chk("R7 status run", d, 32'h1);
  endtask

  task automatic t_global();
    logic [31:0] d;
    bus_gnt[8:6] = 3'b111;
    wr(cfg_a(6), 32'h3);
    wr(cfg_a(7), 32'h3);
    wr(12'h000, 32'h1);
    step(3);
    rd(12'h000, d);    chk("R8 pd readback", d, 32'h1);
    rd(stat_a(6), d);  chk("R8 leaf 6 sleep1", d, 32'hF);
    rd(stat_a(7), d);  chk("R8 leaf 7 sleep1", d, 32'hF);
    rd(stat_a(8), d);  chk("R8 leaf 8 not enrolled runs", d, 32'h1);
    chk("R8 leaf 8 clk on", 32'(leaf_clk_en[8]), 32'h1);
    rd(12'h004, d);    chk("R9 branch 3 asleep", d, 32'h1FF7);
    wr(12'h000, 32'h0);
    step(1);
    chk("R6 R8 enrolled wake", 32'(leaf_clk_en[7:6]), 32'h3);
    wr(cfg_a(6), 32'h2);
    step(2);
    rd(stat_a(6), d);  chk("R8 enrolled ignores run-enable", d, 32'h2);
    chk("R8 enrolled clk on", 32'(leaf_clk_en[6]), 32'h1);
    wr(cfg_a(6), 32'h1);
    wr(cfg_a(7), 32'h1);
    bus_gnt[8:6] = 3'b000;
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(stat_a(0), 32'hFFFF_FFFF);
    wr(12'h004, 32'h0);
    step(2);
    rd(cfg_a(0), d);   chk("R10 cfg unchanged", d, 32'h1);
    rd(stat_a(0), d);  chk("R10 status unchanged", d, 32'h1);
    rd(12'h004, d);    chk("R10 branch unchanged", d, 32'h1FFF);
    rd(12'h000, d);    chk("R10 pd unchanged", d, 32'h0);
    chk("R10 clk unchanged", 32'(leaf_clk_en), 32'h3FF_FFFF);
    rd(12'h080, d);    chk("R2 unmapped reads 0", d, 32'h0);
    bus_gnt[10] = 1'b1;
    step(3);
    chk("R11 grant in run ignored clk", 32'(leaf_clk_en[10]), 32'h1);
    chk("R11 grant in run ignored req", 32'(bus_req[10]), 32'h0);
    rd(stat_a(10), d); chk("R11 status run", d, 32'h1);
    bus_gnt[10] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #200000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_handshake();
    t_branch();
    t_abort();
    t_global();
    t_ignored();
    finish_run();
  end

endmodule